// File: doc/BRIEF.md
# Cycle Timer and Interrupt Scheduler Coprocessor

This block is a test coprocessor that sits beside a processor core. It holds sixteen 32-bit registers. The core loads and reads them through single register transfers or through block transfers, and a free-running cycle counter starts at zero on reset. Data-processing commands treat a selected register as a cycle count. With that count the block can hold the core in a busy stall, schedule either of two active-low interrupt lines (a fast one and a normal one), release those lines, or copy the cycle counter into a register.

The core decodes the instruction and presents the relevant fields on separate inputs. These are the opcode field (instruction bits 23:20), the transfer register field (bits 19:16), the block register field (bits 15:12), the operand register field (bits 3:0) and the long-transfer flag (bit 22). A select input says which of the two coprocessor numbers the block was addressed by. A command is held on `cmd_req` until the block answers with anything other than busy.

Top module: `cyc_sched_cop`

## Requirements
- R1: When `rt_wr` is high, `wr_data` is written at the clock edge into the register chosen by `rn_sel` (instruction bits 19:16). `rt_rdata` always shows the register chosen by `rn_sel`, combinationally.
- R2: Command 0 (`opc`=0) is legal on either coprocessor number. It takes its count from the register chosen by `crm` (instruction bits 3:0). A zero count answers done (`resp`=01) in the issue cycle. A count N answers busy (`resp`=10) while held and answers done in the Nth cycle after the issue cycle.
- R3: Command 1 on the second number (`cp_sel`=1) with count N drives `fiq_n` low after the Nth clock edge that follows the accepting edge, or right after the accepting edge when N is 0. The line then stays low.
- R4: Command 2 does the same for `irq_n`, using a delay counter of its own, so both delays can run at once.
- R5: Command 3 drives `fiq_n` high and cancels a pending fast interrupt. Command 4 does the same for `irq_n`.
- R6: Command 5 writes the cycle count into the register chosen by `crm`. The value written is the number of clock edges since reset, taken at the accepting edge.
- R7: On the first number (`cp_sel`=0) any nonzero opcode answers cannot-handle (`resp`=11). On the second number an opcode above 5 answers cannot-handle. A rejected command changes no register and no interrupt line.
- R8: A block data word with `blk_load`=1 writes `wr_data` into the register chosen by `rd_sel` (instruction bits 15:12). `blk_rdata` always shows that register.
- R9: After `blk_start`, a long transfer (`long_xfer`=1) raises `blk_more` on its first LONG_WORDS-1 data words and lowers it on the next one (the 5th with the default). A short transfer never raises `blk_more`.
- R10: After reset all registers read zero, both interrupt lines are high, and `resp` is 00 whenever `cmd_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_req | input | 1 | Data-processing command held until answered |
| cp_sel | input | 1 | 0 = first coprocessor number, 1 = second |
| opc | input | 4 | Opcode field, instruction bits 23:20 |
| crm | input | 4 | Operand register field, instruction bits 3:0 |
| rn_sel | input | 4 | Register transfer field, instruction bits 19:16 |
| rd_sel | input | 4 | Block transfer register field, instruction bits 15:12 |
| long_xfer | input | 1 | Long block transfer flag, instruction bit 22 |
| rt_wr | input | 1 | Register transfer write strobe |
| blk_start | input | 1 | First step of a block transfer, clears the word count |
| blk_data | input | 1 | A block transfer data word this cycle |
| blk_load | input | 1 | 1 = block word goes into the register, 0 = comes out |
| wr_data | input | 32 | Write data for register and block transfers |
| resp | output | 2 | 00 idle, 01 done, 10 busy, 11 cannot-handle |
| fiq_n | output | 1 | Fast interrupt, active low |
| irq_n | output | 1 | Normal interrupt, active low |
| rt_rdata | output | 32 | Register chosen by `rn_sel` |
| blk_rdata | output | 32 | Register chosen by `rd_sel` |
| blk_more | output | 1 | Long transfer wants another word |

## Verification
The assertions assume that in any one cycle the core does at most one of these three things: issue a register write, issue a block load word, or hold a command. They also assume that a command's fields stay stable while it is answered busy. The bench keeps to both assumptions by running each transfer or command in its own task, with idle cycles between tasks. Its delays are short enough that the cycle counter never wraps, so completion by comparison and completion by countdown must agree.

// File: rtl/cyc_sched_cop.sv
module cyc_sched_cop #(
  parameter int DW         = 32,
  parameter int LONG_WORDS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_req,
  input  logic          cp_sel,
  input  logic [3:0]    opc,
  input  logic [3:0]    crm,
  input  logic [3:0]    rn_sel,
  input  logic [3:0]    rd_sel,
  input  logic          long_xfer,
  input  logic          rt_wr,
  input  logic          blk_start,
  input  logic          blk_data,
  input  logic          blk_load,
  input  logic [DW-1:0] wr_data,
  output logic [1:0]    resp,
  output logic          fiq_n,
  output logic          irq_n,
  output logic [DW-1:0] rt_rdata,
  output logic [DW-1:0] blk_rdata,
  output logic          blk_more
);
  localparam int NREG = 16;
  localparam int WCW  = $clog2(LONG_WORDS) + 1;
  localparam logic [1:0] R_IDLE = 2'b00, R_DONE = 2'b01, R_BUSY = 2'b10, R_CANT = 2'b11;

  logic [DW-1:0]  regs [NREG];
  logic [DW-1:0]  cyc_q, fin_q, count, fin_diff;
  logic           wait_q, illegal, fire, reached;
  logic [WCW-1:0] wcnt_q;
  logic [1:0]     lvl;

  assign count     = regs[crm];
  assign rt_rdata  = regs[rn_sel];
  assign blk_rdata = regs[rd_sel];
  assign fin_diff  = cyc_q - fin_q;
  assign reached   = ~fin_diff[DW-1];
  assign illegal   = (!cp_sel && opc != 4'd0) || (opc > 4'd5);
  assign fire      = cmd_req && !wait_q && !illegal;
  assign blk_more  = blk_data && long_xfer && (wcnt_q != WCW'(LONG_WORDS - 1));

  always_comb begin
    if (!cmd_req)                         resp = R_IDLE;
    else if (wait_q)                      resp = reached ? R_DONE : R_BUSY;
    else if (illegal)                     resp = R_CANT;
    else if (opc == 4'd0 && count != '0)  resp = R_BUSY;
    else                                  resp = R_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      wait_q <= 1'b0;
      fin_q  <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (!cmd_req)
        wait_q <= 1'b0;
      else if (wait_q) begin
        if (reached) wait_q <= 1'b0;
      end else if (fire && opc == 4'd0 && count != '0) begin
        wait_q <= 1'b1;
        fin_q  <= cyc_q + count;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (rt_wr) begin
      regs[rn_sel] <= wr_data;
    end else if (blk_data && blk_load) begin
      regs[rd_sel] <= wr_data;
    end else if (fire && opc == 4'd5) begin
      regs[crm] <= cyc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wcnt_q <= '0;
    else if (blk_start) wcnt_q <= '0;
    else if (blk_more)  wcnt_q <= wcnt_q + 1'b1;
  end

  for (genvar k = 0; k < 2; k++) begin : g_ch
    logic          lvl_q, pend_q;
    logic [DW-1:0] cnt_q;
    logic          set_k, clr_k;
    assign set_k = fire && opc == 4'(1 + k);
    assign clr_k = fire && opc == 4'(3 + k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q  <= 1'b0;
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else if (clr_k) begin
        lvl_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (set_k) begin
        if (count == '0) begin
          lvl_q  <= 1'b1;
          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b1;
          cnt_q  <= count;
        end
      end else if (pend_q) begin
        if (cnt_q == DW'(1)) begin
          lvl_q  <= 1'b1;
          pend_q <= 1'b0;
        end
        cnt_q <= cnt_q - 1'b1;
      end
    end
    assign lvl[k] = lvl_q;
  end

  assign fiq_n = ~lvl[0];
  assign irq_n = ~lvl[1];

  a_r10_idle_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_req |-> resp == R_IDLE);
  a_r2_zero_count_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !wait_q && opc == 4'd0 && count == '0 |-> resp == R_DONE);
  a_r3_zero_delay_fiq: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !wait_q && cp_sel && opc == 4'd1 && count == '0 |=> !fiq_n);
  a_r4_zero_delay_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !wait_q && cp_sel && opc == 4'd2 && count == '0 |=> !irq_n);
  a_r5_release_fiq: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !wait_q && cp_sel && opc == 4'd3 |=> fiq_n);
  a_r5_release_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !wait_q && cp_sel && opc == 4'd4 |=> irq_n);
  a_r7_reject_first: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !wait_q && !cp_sel && opc != 4'd0 |-> resp == R_CANT);
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !wait_q && cp_sel && opc == 4'd5 && !rt_wr && !(blk_data && blk_load)
    |=> regs[$past(crm)] == $past(cyc_q));
  a_r9_more_only_long: assert property (@(posedge clk) disable iff (!rst_n)
    blk_more |-> blk_data && long_xfer);
endmodule

// File: tb/cyc_sched_cop_bench.sv
module cyc_sched_cop_bench;
  localparam int LW = 5;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cmd_req, cp_sel, rt_wr, blk_start, blk_data, blk_load, long_xfer;
  logic [3:0] opc, crm, rn_sel, rd_sel;
  logic [31:0] wr_data, rt_rdata, blk_rdata;
  logic [1:0] resp;
  logic fiq_n, irq_n, blk_more;

  cyc_sched_cop #(.DW(32), .LONG_WORDS(LW)) u_cyc_sched_cop (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cp_sel(cp_sel), .opc(opc), .crm(crm),
    .rn_sel(rn_sel), .rd_sel(rd_sel), .long_xfer(long_xfer), .rt_wr(rt_wr),
    .blk_start(blk_start), .blk_data(blk_data), .blk_load(blk_load), .wr_data(wr_data),
    .resp(resp), .fiq_n(fiq_n), .irq_n(irq_n), .rt_rdata(rt_rdata), .blk_rdata(blk_rdata),
    .blk_more(blk_more));

  int checks = 0, fails = 0;
  bit chk_en = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_reg [16];
  longint m_cyc, m_fin;
  bit m_wait;
  bit m_lvl [2];
  bit m_pend [2];
  longint m_due [2];
  int m_wcnt;

  function automatic logic [1:0] m_resp();
    if (!cmd_req) return 2'b00;
    if (m_wait) return (m_cyc >= m_fin) ? 2'b01 : 2'b10;
    if ((!cp_sel && opc != 0) || opc > 5) return 2'b11;
    if (opc == 0 && m_reg[crm] != 0) return 2'b10;
    return 2'b01;
  endfunction

  function automatic logic m_more();
    return blk_data && long_xfer && (m_wcnt != LW - 1);
  endfunction

  always @(posedge clk) begin
    logic [1:0] r;
    logic [31:0] cnt;
    bit was_wait, more;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_reg[i] = 0;
      m_cyc = 0; m_fin = 0; m_wait = 0; m_wcnt = 0;
      for (int k = 0; k < 2; k++) begin m_lvl[k] = 0; m_pend[k] = 0; m_due[k] = 0; end
    end else begin
      r = m_resp();
      cnt = m_reg[crm];
      was_wait = m_wait;
      more = m_more();
      if (rt_wr) m_reg[rn_sel] = wr_data;
      else if (blk_data && blk_load) m_reg[rd_sel] = wr_data;
      else if (cmd_req && !was_wait && r == 2'b01 && cp_sel && opc == 5) m_reg[crm] = m_cyc[31:0];
      if (!cmd_req) m_wait = 0;
      else if (was_wait) begin if (r == 2'b01) m_wait = 0; end
      else if (r == 2'b10) begin m_wait = 1; m_fin = m_cyc + cnt; end
      if (cmd_req && !was_wait && r == 2'b01 && cp_sel) begin
        if (opc == 1 || opc == 2) begin m_pend[opc-1] = 1; m_due[opc-1] = m_cyc + cnt; end
        if (opc == 3 || opc == 4) begin m_lvl[opc-3] = 0; m_pend[opc-3] = 0; end
      end
      for (int k = 0; k < 2; k++)
        if (m_pend[k] && m_cyc == m_due[k]) begin m_lvl[k] = 1; m_pend[k] = 0; end
      if (blk_start) m_wcnt = 0;
      else if (more) m_wcnt++;
      m_cyc++;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_en) begin
      #2;
      chk("R2 resp", {30'd0, resp}, {30'd0, m_resp()});
      chk("R3 fiq_n", {31'd0, fiq_n}, {31'd0, !m_lvl[0]});
      chk("R4 irq_n", {31'd0, irq_n}, {31'd0, !m_lvl[1]});
      chk("R1 rt_rdata", rt_rdata, m_reg[rn_sel]);
      chk("R8 blk_rdata", blk_rdata, m_reg[rd_sel]);
      chk("R9 blk_more", {31'd0, blk_more}, {31'd0, m_more()});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); rt_wr = 1; rn_sel = a; wr_data = d;
    @(negedge clk); rt_wr = 0;
  endtask

  task automatic cmd(input logic cp, input logic [3:0] op, input logic [3:0] c,
                     output int waited, output logic [1:0] last, output longint at_cyc);
    @(negedge clk); cmd_req = 1; cp_sel = cp; opc = op; crm = c;
    #2; waited = 0;
    while (resp == 2'b10) begin @(negedge clk); #2; waited++; end
    last = resp; at_cyc = m_cyc;
    @(negedge clk); cmd_req = 0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic blk(input logic ld, input logic [3:0] sel, input logic lng, input int n,
                     input logic [31:0] base);
    @(negedge clk); blk_start = 1; rd_sel = sel; long_xfer = lng; blk_load = ld;
    @(negedge clk); blk_start = 0;
    for (int i = 0; i < n; i++) begin
      blk_data = 1; wr_data = base + i; #2;
      chk("R9 more pattern", {31'd0, blk_more}, {31'd0, lng && (i < LW - 1)});
      @(negedge clk);
    end
    blk_data = 0;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int w; logic [1:0] r; longint cap, tmp; logic [31:0] lcg;
    rst_n = 0; cmd_req = 0; cp_sel = 0; opc = 0; crm = 0; rn_sel = 5; rd_sel = 0;
    long_xfer = 0; rt_wr = 0; blk_start = 0; blk_data = 0; blk_load = 0; wr_data = 0;
    cycles(3);
    rst_n = 1;
    #2;
    chk("R10 resp idle", {30'd0, resp}, 0);
    chk("R10 fiq_n", {31'd0, fiq_n}, 1);
    chk("R10 irq_n", {31'd0, irq_n}, 1);
    chk("R10 reg zero", rt_rdata, 0);
    chk_en = 1;

    wr(4'd2, 32'd3); wr(4'd3, 32'd7); wr(4'd4, 32'd1); wr(4'd7, 32'hdead_beef);
    rn_sel = 4'd7; #2; chk("R1 readback", rt_rdata, 32'hdead_beef);

    cmd(0, 0, 1, w, r, tmp);
    chk("R2 zero count waits", w, 0); chk("R2 zero count done", {30'd0, r}, 1);
    cmd(1, 0, 2, w, r, tmp);
    chk("R2 busy cycles", w, 3); chk("R2 busy ends done", {30'd0, r}, 1);
    cmd(0, 0, 4, w, r, tmp);
    chk("R2 first number count 1", w, 1);

    cmd(1, 1, 1, w, r, tmp); #2;
    chk("R3 immediate fiq", {31'd0, fiq_n}, 0);
    cmd(1, 3, 0, w, r, tmp); #2;
    chk("R5 fiq released", {31'd0, fiq_n}, 1);

    cmd(1, 1, 2, w, r, tmp);
    cycles(2); #2; chk("R3 fiq not yet", {31'd0, fiq_n}, 1);
    cycles(1); #2; chk("R3 fiq after 3", {31'd0, fiq_n}, 0);

    cmd(1, 2, 3, w, r, tmp);
    cycles(6); #2; chk("R4 irq not yet", {31'd0, irq_n}, 1);
    cycles(1); #2; chk("R4 irq after 7", {31'd0, irq_n}, 0);
    chk("R4 fiq unaffected", {31'd0, fiq_n}, 0);
    cmd(1, 4, 0, w, r, tmp); #2;
    chk("R5 irq released", {31'd0, irq_n}, 1);
    chk("R5 fiq still low", {31'd0, fiq_n}, 0);

    cmd(1, 3, 0, w, r, tmp);
    cmd(1, 1, 3, w, r, tmp);
    cmd(1, 3, 0, w, r, tmp);
    cycles(10); #2;
    chk("R5 pending fiq cancelled", {31'd0, fiq_n}, 1);

    cmd(1, 5, 6, w, r, cap);
    rn_sel = 4'd6; #2;
    chk("R6 captured cycle", rt_rdata, cap[31:0]);

    cmd(0, 1, 1, w, r, tmp);
    chk("R7 first number op1", {30'd0, r}, 3);
    cycles(3); #2; chk("R7 no fiq", {31'd0, fiq_n}, 1);
    cmd(1, 6, 1, w, r, tmp);
    chk("R7 op6 rejected", {30'd0, r}, 3);
    cmd(0, 5, 6, w, r, tmp);
    chk("R7 capture rejected", {30'd0, r}, 3);
    rn_sel = 4'd6; #2;
    chk("R7 reg unchanged", rt_rdata, cap[31:0]);

    blk(1, 4'd9, 0, 1, 32'h1234_5678);
    rd_sel = 4'd9; #2; chk("R8 short load", blk_rdata, 32'h1234_5678);
    blk(1, 4'd10, 1, LW, 32'hA000_0000);
    rd_sel = 4'd10; #2; chk("R8 long load last word", blk_rdata, 32'hA000_0000 + LW - 1);
    blk(0, 4'd10, 1, LW, 32'h0);
    blk(0, 4'd9, 0, 1, 32'h0);

    lcg = 32'h1357_9bdf;
    for (int i = 0; i < 20; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      wr(lcg[3:0], lcg);
      rn_sel = lcg[3:0]; #2;
      chk("R1 pattern", rt_rdata, lcg);
    end

    cycles(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule